// File: doc/BRIEF.md
# Prioritized Interrupt Collector

This block gathers a bank of level-sensitive interrupt lines and presents one request to a processor. Each source has a small control word with an enable bit and a two-bit priority. An arbiter picks one pending, enabled source. The highest priority wins, and among sources at the same level the lowest source number wins. The chosen source is reported through a status word, and the processor request is raised while such a source exists.

The handler reads status and then writes the vector register to begin servicing. From that point, requests at the serviced level and at every level below it are held off. A request at a strictly higher level is still presented. The handler ends servicing with a write to the level-acknowledge register, which carries one bit per level. Writing 0x1 retires level 0.

Every register sits in a 16-byte slot of four word addresses. Byte offset 0x0 is a plain write. Offset 0x4 ORs the written bits into the register, offset 0x8 clears them, and offset 0xC toggles them. A read at any of the four addresses returns the same value. A soft-clear command sets every source priority back to level 0.

Top module: `icol_top`

## Requirements
- R1: After reset every source control word reads 0, `irq_o` is low, and status reads 0x7F with its valid bit (bit 8) clear.
- R2: The control word of source n is at byte address 0x120 + 16*n. Bit 2 is the enable and bits [1:0] are the priority. All other bits read as 0.
- R3: Within any slot, address offset 0x4 ORs the written bits into the register, 0x8 clears the bits written as one, and 0xC toggles them. A read at 0x4, 0x8 or 0xC returns the same value as a read at 0x0.
- R4: A source whose enable bit is clear never raises `irq_o` and is never reported in status.
- R5: Status (address 0x70) returns the selected source number in bits [6:0] with bit 8 set. The selected source is the pending enabled source with the highest priority.
- R6: When several eligible sources share the top priority, the one with the lowest number is selected.
- R7: A write to the vector register (address 0x00) while a request is presented latches the source number, which reads back at 0x00. It marks that source's level in service. After that, only sources with a strictly higher priority than the highest level in service can be presented.
- R8: A write to the level-acknowledge register (address 0x10) retires each level whose bit is set, with bit l meaning level l. Writing 0x1 retires level 0.
- R9: Writing bit 0 as one to the control register (address 0x20), through the plain, set or toggle alias, clears every priority to 0 and leaves the enables unchanged. The clear alias has no effect.
- R10: `irq_o` follows the status valid bit in the same cycle. It falls without a clock edge when the selected source's line drops and no other source is eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Level-sensitive interrupt lines |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register byte address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data (combinational from the address) |
| irq_o | output | 1 | Request to the processor |

## Verification
A corrupted control word shows up at once as a wrong status number or a request that should not be there, both visible in the cycle after the write. If the in-service state is not set, the request stays high straight after a vector write instead of dropping. If that state is not cleared, the request stays low after an acknowledge even though a source at that level is pending. Each of these shows on `irq_o` and in status within one clock. A wrong tie-break or level comparison returns a wrong source number in the first status read with competing sources.

// File: rtl/icol_pkg.sv
package icol_pkg;
  localparam int LVL_W          = 2;
  localparam int NUM_LVL        = 1 << LVL_W;
  localparam int CTRL_W         = LVL_W + 1;
  localparam int EN_BIT         = 2;
  localparam int STAT_VALID_BIT = 8;

  // register slots: byte address >> 4
  localparam int SLOT_VEC  = 0;
  localparam int SLOT_ACK  = 1;
  localparam int SLOT_CTRL = 2;
  localparam int SLOT_STAT = 7;
  localparam int SLOT_SRC0 = 18;

  typedef enum logic [1:0] {
    OP_WR  = 2'd0,
    OP_SET = 2'd1,
    OP_CLR = 2'd2,
    OP_TOG = 2'd3
  } icol_op_e;

  function automatic logic [CTRL_W-1:0] apply_op(icol_op_e op, logic [CTRL_W-1:0] cur,
                                                  logic [CTRL_W-1:0] val);
    case (op)
      OP_SET:  return cur | val;
      OP_CLR:  return cur & ~val;
      OP_TOG:  return cur ^ val;
      default: return val;
    endcase
  endfunction
endpackage

// File: rtl/icol_regfile.sv
module icol_regfile import icol_pkg::*; #(
  parameter int NUM_SRC = 128,
  localparam int ID_W   = $clog2(NUM_SRC)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_i,
  input  logic [ID_W-1:0]                  wr_idx_i,
  input  icol_op_e                         op_i,
  input  logic [CTRL_W-1:0]                wdata_i,
  input  logic                             prio_clr_i,
  output logic [NUM_SRC-1:0]               en_o,
  output logic [NUM_SRC-1:0][LVL_W-1:0]    prio_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [CTRL_W-1:0] ctrl_q, ctrl_d;
    logic              hit;

    assign hit = wr_i && (wr_idx_i == ID_W'(i));

    always_comb begin
      ctrl_d = ctrl_q;
      if (hit) ctrl_d = apply_op(op_i, ctrl_q, wdata_i);
      if (prio_clr_i) ctrl_d[LVL_W-1:0] = '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ctrl_q <= '0;
      else         ctrl_q <= ctrl_d;
    end

    assign en_o[i]   = ctrl_q[EN_BIT];
    assign prio_o[i] = ctrl_q[LVL_W-1:0];
  end
endmodule

// File: rtl/icol_arbiter.sv
module icol_arbiter import icol_pkg::*; #(
  parameter int NUM_SRC = 128,
  localparam int ID_W   = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]            pend_i,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] prio_i,
  input  logic                          thr_valid_i,
  input  logic [LVL_W-1:0]              thr_i,
  output logic                          valid_o,
  output logic [ID_W-1:0]               id_o,
  output logic [LVL_W-1:0]              lvl_o
);
  logic [NUM_LVL-1:0]           lvl_hit;
  logic [NUM_LVL-1:0][ID_W-1:0] lvl_id;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    logic elig;
    assign elig = !thr_valid_i || (LVL_W'(l) > thr_i);

    // descending scan: the lowest index is assigned last and wins
    always_comb begin
      lvl_hit[l] = 1'b0;
      lvl_id[l]  = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
        if (elig && pend_i[i] && (prio_i[i] == LVL_W'(l))) begin
          lvl_hit[l] = 1'b1;
          lvl_id[l]  = ID_W'(i);
        end
      end
    end
  end

  always_comb begin
    valid_o = 1'b0;
    id_o    = '1;
    lvl_o   = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (lvl_hit[l]) begin
        valid_o = 1'b1;
        id_o    = lvl_id[l];
        lvl_o   = LVL_W'(l);
      end
    end
  end
endmodule

// File: rtl/icol_svc.sv
module icol_svc import icol_pkg::*; #(
  parameter int NUM_SRC = 128,
  localparam int ID_W   = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               vec_wr_i,
  input  logic               ack_wr_i,
  input  logic [NUM_LVL-1:0] ack_bits_i,
  input  logic               sel_valid_i,
  input  logic [ID_W-1:0]    sel_id_i,
  input  logic [LVL_W-1:0]   sel_lvl_i,
  output logic [NUM_LVL-1:0] in_svc_o,
  output logic               thr_valid_o,
  output logic [LVL_W-1:0]   thr_o,
  output logic [ID_W-1:0]    vec_o
);
  logic [NUM_LVL-1:0] in_svc_q;
  logic [ID_W-1:0]    vec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_svc_q <= '0;
      vec_q    <= '1;
    end else if (ack_wr_i) begin
      in_svc_q <= in_svc_q & ~ack_bits_i;
    end else if (vec_wr_i && sel_valid_i) begin
      in_svc_q[sel_lvl_i] <= 1'b1;
      vec_q               <= sel_id_i;
    end
  end

  always_comb begin
    thr_o = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (in_svc_q[l]) thr_o = LVL_W'(l);
    end
  end

  assign thr_valid_o = |in_svc_q;
  assign in_svc_o    = in_svc_q;
  assign vec_o       = vec_q;
endmodule

// File: rtl/icol_top.sv
module icol_top import icol_pkg::*; #(
  parameter int NUM_SRC = 128,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic               irq_o
);
  localparam int ID_W   = $clog2(NUM_SRC);
  localparam int SLOT_W = ADDR_W - 4;

  logic [SLOT_W-1:0] slot, src_off;
  icol_op_e          op;
  logic              in_src;
  logic [ID_W-1:0]   src_idx;
  logic              src_wr, vec_wr, ack_wr, ctrl_wr, soft_clr;

  logic [NUM_SRC-1:0]            src_en;
  logic [NUM_SRC-1:0][LVL_W-1:0] src_prio;
  logic                          sel_valid;
  logic [ID_W-1:0]               sel_id, vec_q;
  logic [LVL_W-1:0]              sel_lvl, thr;
  logic                          thr_valid;
  logic [NUM_LVL-1:0]            in_svc;

  assign slot    = bus_addr_i[ADDR_W-1:4];
  assign op      = icol_op_e'(bus_addr_i[3:2]);
  assign src_off = slot - SLOT_W'(SLOT_SRC0);
  assign in_src  = (slot >= SLOT_W'(SLOT_SRC0)) && (int'(src_off) < NUM_SRC);
  assign src_idx = src_off[ID_W-1:0];

  assign src_wr   = bus_we_i && in_src;
  assign vec_wr   = bus_we_i && (slot == SLOT_W'(SLOT_VEC));
  assign ack_wr   = bus_we_i && (slot == SLOT_W'(SLOT_ACK));
  assign ctrl_wr  = bus_we_i && (slot == SLOT_W'(SLOT_CTRL));
  assign soft_clr = ctrl_wr && (op != OP_CLR) && bus_wdata_i[0];

  icol_regfile #(.NUM_SRC(NUM_SRC)) u_regfile (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (src_wr),
    .wr_idx_i   (src_idx),
    .op_i       (op),
    .wdata_i    (bus_wdata_i[CTRL_W-1:0]),
    .prio_clr_i (soft_clr),
    .en_o       (src_en),
    .prio_o     (src_prio)
  );

  icol_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .pend_i      (src_i & src_en),
    .prio_i      (src_prio),
    .thr_valid_i (thr_valid),
    .thr_i       (thr),
    .valid_o     (sel_valid),
    .id_o        (sel_id),
    .lvl_o       (sel_lvl)
  );

  icol_svc #(.NUM_SRC(NUM_SRC)) u_svc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .vec_wr_i    (vec_wr),
    .ack_wr_i    (ack_wr),
    .ack_bits_i  (bus_wdata_i[NUM_LVL-1:0]),
    .sel_valid_i (sel_valid),
    .sel_id_i    (sel_id),
    .sel_lvl_i   (sel_lvl),
    .in_svc_o    (in_svc),
    .thr_valid_o (thr_valid),
    .thr_o       (thr),
    .vec_o       (vec_q)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (in_src) begin
      bus_rdata_o[EN_BIT]      = src_en[src_idx];
      bus_rdata_o[LVL_W-1:0]   = src_prio[src_idx];
    end else if (slot == SLOT_W'(SLOT_STAT)) begin
      bus_rdata_o[ID_W-1:0]       = sel_id;
      bus_rdata_o[STAT_VALID_BIT] = sel_valid;
    end else if (slot == SLOT_W'(SLOT_VEC)) begin
      bus_rdata_o[ID_W-1:0] = vec_q;
    end
  end

  assign irq_o = sel_valid;
endmodule

// File: rtl/icol_chk.sv
module icol_chk import icol_pkg::*; #(
  parameter int NUM_SRC = 128,
  parameter int ID_W    = 7
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [NUM_SRC-1:0]            src_i,
  input logic [NUM_SRC-1:0]            en,
  input logic [NUM_SRC-1:0][LVL_W-1:0] prio,
  input logic                          irq_o,
  input logic [ID_W-1:0]               sel_id,
  input logic [LVL_W-1:0]              sel_lvl,
  input logic [NUM_LVL-1:0]            in_svc,
  input logic                          vec_wr,
  input logic                          ack_wr,
  input logic [NUM_LVL-1:0]            ack_bits,
  input logic                          soft_clr
);
  p_idle_code_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (sel_id == '1));

  p_masked_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> |(src_i & en));

  p_sel_enabled_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (en[sel_id] && src_i[sel_id]));

  p_holdoff_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_wr && irq_o) |=> (!irq_o || (sel_lvl > $past(sel_lvl))));

  p_ack_retire_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_wr |=> ((in_svc & $past(ack_bits)) == '0));

  p_soft_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_clr |=> (prio == '0));
endmodule

bind icol_top icol_chk #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .src_i    (src_i),
  .en       (src_en),
  .prio     (src_prio),
  .irq_o    (irq_o),
  .sel_id   (sel_id),
  .sel_lvl  (sel_lvl),
  .in_svc   (in_svc),
  .vec_wr   (vec_wr),
  .ack_wr   (ack_wr),
  .ack_bits (bus_wdata_i[NUM_LVL-1:0]),
  .soft_clr (soft_clr)
);

// File: tb/icol_top_tb.sv
module icol_top_tb;
  localparam int N = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  icol_top #(.NUM_SRC(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [11:0] sa(int n);
    return 12'(32'h120 + n * 16);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = 12'h000; wdata = '0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
    addr = 12'h000;
  endtask

  task automatic clean();
    src = '0;
    for (int i = 0; i < N; i++) wr(sa(i), 32'h0);
    wr(12'h010, 32'hF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(12'h070, d); chk("R1 status", d, 32'h7F);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(sa(5), d);   chk("R1 ctrl5", d, 32'h0);
    rd(sa(127), d); chk("R1 ctrl127", d, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(sa(3), 32'hFFFF_FFFF);
    rd(sa(3), d);                chk("R2 fields", d, 32'h7);
    wr(sa(3) + 12'h8, 32'h4);
    rd(sa(3), d);                chk("R3 clr", d, 32'h3);
    wr(sa(3) + 12'h4, 32'h4);
    rd(sa(3), d);                chk("R3 set", d, 32'h7);
    wr(sa(3) + 12'hC, 32'h3);
    rd(sa(3), d);                chk("R3 tog", d, 32'h4);
    rd(sa(3) + 12'h4, d);        chk("R3 read set alias", d, 32'h4);
    rd(sa(3) + 12'hC, d);        chk("R3 read tog alias", d, 32'h4);
    rd(sa(4), d);                chk("R2 neighbour", d, 32'h0);
    clean();
  endtask

  task automatic t_disable();
    logic [31:0] d;
    src[10] = 1'b1;
    wr(sa(10), 32'h3);
    rd(12'h070, d);  chk("R4 disabled status", d, 32'h7F);
    chk("R4 disabled irq", {31'b0, irq}, 32'h0);
    wr(sa(10) + 12'h4, 32'h4);
    rd(12'h070, d);  chk("R4 enabled status", d, 32'h10A);
    chk("R10 irq high", {31'b0, irq}, 32'h1);
    src[10] = 1'b0;
    #1;
    chk("R10 irq drops", {31'b0, irq}, 32'h0);
    clean();
  endtask

  task automatic t_prio();
    logic [31:0] d;
    wr(sa(10), 32'h4); wr(sa(40), 32'h6); wr(sa(90), 32'h5);
    src[10] = 1'b1; src[40] = 1'b1; src[90] = 1'b1;
    rd(12'h070, d);  chk("R5 highest", d, 32'h128);
    src[40] = 1'b0;
    rd(12'h070, d);  chk("R5 next", d, 32'h15A);
    wr(sa(20), 32'h7); wr(sa(70), 32'h7);
    src[70] = 1'b1; src[20] = 1'b1;
    rd(12'h070, d);  chk("R6 tie lowest", d, 32'h114);
    clean();
  endtask

  task automatic t_service();
    logic [31:0] d;
    wr(sa(5), 32'h5); wr(sa(6), 32'h5); wr(sa(8), 32'h6);
    src[5] = 1'b1; src[6] = 1'b1;
    rd(12'h070, d);  chk("R7 before", d, 32'h105);
    wr(12'h000, 32'h0);
    rd(12'h070, d);  chk("R7 held status", d, 32'h7F);
    chk("R7 held irq", {31'b0, irq}, 32'h0);
    rd(12'h000, d);  chk("R7 vector", d, 32'h5);
    src[8] = 1'b1;
    rd(12'h070, d);  chk("R7 higher passes", d, 32'h108);
    wr(12'h000, 32'h0);
    rd(12'h070, d);  chk("R7 nested held", d, 32'h7F);
    wr(12'h010, 32'h4);
    rd(12'h070, d);  chk("R8 ack level2", d, 32'h108);
    src[8] = 1'b0;
    rd(12'h070, d);  chk("R8 level1 still held", d, 32'h7F);
    wr(12'h010, 32'h2);
    rd(12'h070, d);  chk("R8 ack level1", d, 32'h105);
    wr(sa(5), 32'h4); wr(sa(6), 32'h0);
    wr(12'h000, 32'h0);
    rd(12'h070, d);  chk("R7 level0 held", d, 32'h7F);
    wr(12'h010, 32'h1);
    rd(12'h070, d);  chk("R8 ack level0", d, 32'h105);
    clean();
  endtask

  task automatic t_soft();
    logic [31:0] d;
    wr(sa(30), 32'h7); wr(sa(31), 32'h6);
    wr(12'h028, 32'h1);
    rd(sa(30), d);   chk("R9 clr alias no effect", d, 32'h7);
    wr(12'h020, 32'h1);
    rd(sa(30), d);   chk("R9 prio cleared 30", d, 32'h4);
    rd(sa(31), d);   chk("R9 prio cleared 31", d, 32'h4);
    wr(sa(30), 32'h3);
    wr(12'h024, 32'h1);
    rd(sa(30), d);   chk("R9 set alias clears", d, 32'h0);
    clean();
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_disable();
    t_prio();
    t_service();
    t_soft();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule